// File: doc/BRIEF.md
# Pipelined wide reduction tree

This block folds a wide input vector down to one bit with a fixed operator: AND, OR or XOR, chosen at compile time. The vector passes through a tree of levels. Each level cuts its input into groups of a fixed fan-in, reduces every group to one bit, and hands the narrower vector to the next level. When a level's width is not a whole multiple of the fan-in, the top of that vector is filled with the operator's neutral bit (one for AND, zero for OR and XOR). Levels repeat until one bit is left.

Pipeline registers can cut the tree after every `MAX_DEPTH` levels. Two separate compile-time switches add a register on the whole input vector and on the one-bit result. This lets a wide parity, all-ones or any-set detector meet a clock target at the cost of a fixed, known latency. There is no handshake. A new vector can be presented on every cycle, and its result appears a constant number of cycles later.

Top module: `wide_reduce_tree`

## Requirements
- R1: With `OP = RED_AND`, `result` is 1 exactly when all `DATA_W` bits of the input it reflects are 1.
- R2: With `OP = RED_OR`, `result` is 1 exactly when at least one bit of the input it reflects is 1.
- R3: With `OP = RED_XOR`, `result` is 1 exactly when the input it reflects has an odd number of ones.
- R4: Level widths are defined as w0 = `DATA_W` and w(s+1) = ceil(ws / `FANIN`). Level s is registered when (s+1) is a multiple of `MAX_DEPTH` and w(s+1) > 1. The latency L equals `IN_REG` + `OUT_REG` + the number of registered levels. The result seen after a rising edge is the reduction of `din` as sampled L edges earlier, counting that edge as the first. With L = 0 the result is combinational.
- R5: When a level width is not a multiple of `FANIN`, the fill bits never change the result. For every operator, the result of all-ones, all-zeros, walking-one and walking-zero vectors equals the plain reduction of the `DATA_W` input bits.
- R6: A high `rst` clears every register at once, without waiting for a clock edge. While `rst` is high, `result` is 0 whenever L > 0. Once `rst` falls, `result` follows R4, with the cleared stages acting as all-zero history (which reduces to 0 for every operator).
- R7: With `DATA_W = 1` the tree has no levels. `result` equals `din` delayed by `IN_REG` + `OUT_REG` cycles.
- R8: If `din` is held constant for more than L + 1 rising edges, `result` stays constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all pipeline registers |
| rst | input | 1 | Active-high asynchronous reset, clears every register |
| din | input | DATA_W | Vector to be reduced |
| result | output | 1 | Reduced bit, L cycles after its input |

## Verification
The assertions assume that `din` is a known value at every rising edge and that `rst` is high from time zero until the first edges have passed. The hold-stability check also assumes that `din` changes only between edges, never at an edge. The bench drives `din` and `rst` only on falling edges and starts with reset held high. It keeps `din` at zero while reset is high, so the cleared pipeline and the reference history agree when reset falls. Five instances with different widths, fan-ins, operators and register placements share one stimulus stream. That stream includes an exhaustive sweep of the low eleven bits, which covers the smallest instance completely.

// File: rtl/red_pkg.sv
package red_pkg;

    typedef enum logic [1:0] {
        RED_AND = 2'd0,
        RED_OR  = 2'd1,
        RED_XOR = 2'd2
    } red_op_e;

    // width of the next level for a level of width w
    function automatic int next_width(input int w, input int f);
        return (w + f - 1) / f;
    endfunction

    // width entering level s (level 0 sees the full input)
    function automatic int level_width(input int w, input int f, input int s);
        int cur;
        cur = w;
        for (int i = 0; i < s; i++) begin
            cur = next_width(cur, f);
        end
        return cur;
    endfunction

    // number of levels needed to fold w bits down to one
    function automatic int level_count(input int w, input int f);
        int cur;
        int n;
        cur = w;
        n   = 0;
        while (cur > 1) begin
            cur = next_width(cur, f);
            n++;
        end
        return n;
    endfunction

    // whether the output of level s is registered
    function automatic bit level_registered(input int w, input int f,
                                            input int s, input int d);
        return (((s + 1) % d) == 0) && (level_width(w, f, s + 1) > 1);
    endfunction

    // registers on the path from din to result
    function automatic int path_latency(input int w, input int f, input bit ri,
                                        input bit ro, input int d);
        int n;
        n = int'(ri) + int'(ro);
        for (int s = 0; s < level_count(w, f); s++) begin
            if (level_registered(w, f, s, d)) begin
                n++;
            end
        end
        return n;
    endfunction

    // neutral fill bit for an operator
    function automatic logic neutral_bit(input red_op_e op);
        return (op == RED_AND);
    endfunction

endpackage

// File: rtl/red_pipe_reg.sv
module red_pipe_reg
    import red_pkg::*;
#(
    parameter int W      = 8,
    parameter bit ENABLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (ENABLE) begin : g_flop
            always_ff @(posedge clk or posedge rst) begin
                if (rst) begin
                    q <= '0;
                end else begin
                    q <= d;
                end
            end

            // R6: reset holds the stage at zero
            assert_reg_clear_R6: assert property (@(posedge clk) rst |-> (q == '0));

            // R4: each enabled stage adds exactly one cycle
            assert_reg_tracks_R4: assert property (@(posedge clk) disable iff (rst)
                !rst |=> (q == $past(d)));
        end else begin : g_wire
            logic unused_ok;
            assign unused_ok = &{1'b0, clk, rst};
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/red_group.sv
module red_group
    import red_pkg::*;
#(
    parameter int      FANIN = 3,
    parameter red_op_e OP    = RED_XOR
) (
    input  logic [FANIN-1:0] bits,
    output logic             y
);

    always_comb begin
        unique case (OP)
            RED_AND: begin
                y = &bits;
                assert_group_and_R1: assert (y == ($countones(bits) == FANIN));
            end
            RED_OR: begin
                y = |bits;
                assert_group_or_R2: assert (y == ($countones(bits) != 0));
            end
            default: begin
                y = ^bits;
                assert_group_xor_R3: assert (y == (($countones(bits) % 2) == 1));
            end
        endcase
    end

endmodule

// File: rtl/red_level.sv
module red_level
    import red_pkg::*;
#(
    parameter int      IN_W    = 8,
    parameter int      FANIN   = 3,
    parameter red_op_e OP      = RED_XOR,
    parameter bit      REG_OUT = 1'b0
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [IN_W-1:0]                       din,
    output logic [((IN_W + FANIN - 1) / FANIN)-1:0] dout
);

    localparam int   OUT_W = (IN_W + FANIN - 1) / FANIN;
    localparam int   PAD_W = OUT_W * FANIN;
    localparam logic FILL  = neutral_bit(OP);

    logic [PAD_W-1:0] padded;
    logic [OUT_W-1:0] grp_out;

    // R5: fill the upper end with the operator's neutral bit
    always_comb begin
        padded            = {PAD_W{FILL}};
        padded[IN_W-1:0]  = din;
    end

    generate
        for (genvar k = 0; k < OUT_W; k++) begin : gen_group
            red_group #(
                .FANIN (FANIN),
                .OP    (OP)
            ) u_group (
                .bits (padded[k*FANIN +: FANIN]),
                .y    (grp_out[k])
            );
        end
    endgenerate

    red_pipe_reg #(
        .W      (OUT_W),
        .ENABLE (REG_OUT)
    ) u_stage (
        .clk (clk),
        .rst (rst),
        .d   (grp_out),
        .q   (dout)
    );

endmodule

// File: rtl/wide_reduce_tree.sv
module wide_reduce_tree
    import red_pkg::*;
#(
    parameter int      DATA_W    = 37,
    parameter int      FANIN     = 3,
    parameter red_op_e OP        = RED_XOR,
    parameter bit      IN_REG    = 1'b1,
    parameter bit      OUT_REG   = 1'b1,
    parameter int      MAX_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    output logic              result
);

    localparam int NLEV    = level_count(DATA_W, FANIN);
    localparam int LATENCY = path_latency(DATA_W, FANIN, IN_REG, OUT_REG, MAX_DEPTH);
    localparam int CNT_W   = $clog2(LATENCY + 4) + 1;
    localparam int CNT_MAX = LATENCY + 3;

    logic [DATA_W-1:0] in_q;
    logic              tree_out;

    red_pipe_reg #(
        .W      (DATA_W),
        .ENABLE (IN_REG)
    ) u_in_stage (
        .clk (clk),
        .rst (rst),
        .d   (din),
        .q   (in_q)
    );

    generate
        for (genvar s = 0; s < NLEV; s++) begin : gen_level
            localparam int IW      = level_width(DATA_W, FANIN, s);
            localparam int OW      = level_width(DATA_W, FANIN, s + 1);
            localparam bit CUT_REG = level_registered(DATA_W, FANIN, s, MAX_DEPTH);

            logic [IW-1:0] lvl_in;
            logic [OW-1:0] lvl_q;

            if (s == 0) begin : g_first
                assign lvl_in = in_q;
            end else begin : g_next
                assign lvl_in = gen_level[s-1].lvl_q;
            end

            red_level #(
                .IN_W    (IW),
                .FANIN   (FANIN),
                .OP      (OP),
                .REG_OUT (CUT_REG)
            ) u_level (
                .clk  (clk),
                .rst  (rst),
                .din  (lvl_in),
                .dout (lvl_q)
            );
        end

        if (NLEV == 0) begin : g_no_tree
            assign tree_out = in_q[0];
        end else begin : g_tree
            assign tree_out = gen_level[NLEV-1].lvl_q[0];
        end
    endgenerate

    red_pipe_reg #(
        .W      (1),
        .ENABLE (OUT_REG)
    ) u_out_stage (
        .clk (clk),
        .rst (rst),
        .d   (tree_out),
        .q   (result)
    );

    // R8: count consecutive edges with an unchanged input
    logic [DATA_W-1:0] hold_din_q;
    logic [CNT_W-1:0]  hold_cnt_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            hold_din_q <= '0;
            hold_cnt_q <= '0;
        end else begin
            hold_din_q <= din;
            if (din != hold_din_q) begin
                hold_cnt_q <= '0;
            end else if (hold_cnt_q != CNT_W'(CNT_MAX)) begin
                hold_cnt_q <= hold_cnt_q + 1'b1;
            end
        end
    end

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
        ((din == hold_din_q) && (hold_cnt_q >= CNT_W'(LATENCY + 2))) |-> $stable(result));

endmodule

// File: tb/wide_reduce_tree_tb_top.sv
module wide_reduce_tree_tb_top;
    import red_pkg::*;

    localparam int CLK_P = 10;
    localparam int NDUT  = 5;

    localparam int P_W  [NDUT] = '{37, 29, 50, 1, 11};
    localparam int P_F  [NDUT] = '{3, 4, 7, 2, 2};
    localparam int P_OP [NDUT] = '{2, 0, 1, 2, 0};   // 0 AND, 1 OR, 2 XOR
    localparam int P_RI [NDUT] = '{1, 0, 1, 1, 0};
    localparam int P_RO [NDUT] = '{1, 1, 0, 1, 0};
    localparam int P_D  [NDUT] = '{2, 1, 3, 1, 5};

    logic            clk;
    logic            rst;
    logic [63:0]     stim;
    logic [NDUT-1:0] res;

    int total;
    int bad;
    int lat  [NDUT];
    logic [63:0] hist [0:7];
    logic samp_s [NDUT];
    logic prev_s [NDUT];
    string tags [NDUT] = '{"R3/R4", "R1/R4", "R2/R4", "R7", "R1/R5"};

    initial clk = 1'b0;
    always #(CLK_P / 2) clk = ~clk;

    wide_reduce_tree #(.DATA_W(37), .FANIN(3), .OP(RED_XOR), .IN_REG(1'b1),
                       .OUT_REG(1'b1), .MAX_DEPTH(2))
        dut_i (.clk(clk), .rst(rst), .din(stim[36:0]), .result(res[0]));
    wide_reduce_tree #(.DATA_W(29), .FANIN(4), .OP(RED_AND), .IN_REG(1'b0),
                       .OUT_REG(1'b1), .MAX_DEPTH(1))
        dut_and (.clk(clk), .rst(rst), .din(stim[28:0]), .result(res[1]));
    wide_reduce_tree #(.DATA_W(50), .FANIN(7), .OP(RED_OR), .IN_REG(1'b1),
                       .OUT_REG(1'b0), .MAX_DEPTH(3))
        dut_or (.clk(clk), .rst(rst), .din(stim[49:0]), .result(res[2]));
    wide_reduce_tree #(.DATA_W(1), .FANIN(2), .OP(RED_XOR), .IN_REG(1'b1),
                       .OUT_REG(1'b1), .MAX_DEPTH(1))
        dut_one (.clk(clk), .rst(rst), .din(stim[0:0]), .result(res[3]));
    wide_reduce_tree #(.DATA_W(11), .FANIN(2), .OP(RED_AND), .IN_REG(1'b0),
                       .OUT_REG(1'b0), .MAX_DEPTH(5))
        dut_comb (.clk(clk), .rst(rst), .din(stim[10:0]), .result(res[4]));

    function automatic int bench_lat(input int w, input int f, input int ri,
                                     input int ro, input int d);
        int n;
        int cur;
        int s;
        n   = ri + ro;
        cur = w;
        s   = 0;
        while (cur > 1) begin
            cur = (cur + f - 1) / f;
            if ((((s + 1) % d) == 0) && (cur > 1)) n++;
            s++;
        end
        return n;
    endfunction

    function automatic logic ref_red(input logic [63:0] v, input int w, input int op);
        logic acc;
        acc = (op == 0);
        for (int i = 0; i < w; i++) begin
            case (op)
                0:       acc = acc & v[i];
                1:       acc = acc | v[i];
                default: acc = acc ^ v[i];
            endcase
        end
        return acc;
    endfunction

    task automatic check(input logic act, input logic exp, input string tag,
                         input string ph, input int d);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s (%s) dut%0d actual=%b expected=%b", tag, ph, d, act, exp);
        end
    endtask

    // one cycle: check at the falling edge, then apply reset level and new data
    task automatic step(input logic [63:0] nv, input logic r, input string ph);
        @(negedge clk);
        for (int d = 0; d < NDUT; d++) begin
            prev_s[d] = samp_s[d];
            samp_s[d] = res[d];
            if (rst) begin
                if (lat[d] > 0) check(res[d], 1'b0, "R6", ph, d);
            end else begin
                int hi;
                hi = (lat[d] > 0) ? lat[d] - 1 : 0;
                check(res[d], ref_red(hist[hi], P_W[d], P_OP[d]), tags[d], ph, d);
            end
        end
        rst = r;
        for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = r ? 64'd0 : nv;
        if (r) begin
            for (int i = 0; i < 8; i++) hist[i] = 64'd0;
        end
        stim = hist[0];
    endtask

    initial begin
        rst   = 1'b1;
        stim  = 64'd0;
        total = 0;
        bad   = 0;
        for (int i = 0; i < 8; i++) hist[i] = 64'd0;
        for (int d = 0; d < NDUT; d++) begin
            lat[d]    = bench_lat(P_W[d], P_F[d], P_RI[d], P_RO[d], P_D[d]);
            samp_s[d] = 1'b0;
            prev_s[d] = 1'b0;
        end

        // R6: reset state and release
        repeat (3) step(64'd0, 1'b1, "R6 reset");
        step(64'd0, 1'b0, "R6 release");
        repeat (4) step(64'd0, 1'b0, "R6 after release");

        // R5: neutral fill on ragged widths
        repeat (8) step({64{1'b1}}, 1'b0, "R5 all-ones");
        repeat (8) step(64'd0, 1'b0, "R5 all-zeros");
        for (int i = 0; i < 64; i++) step(64'd1 << i, 1'b0, "R5 walking-one");
        for (int i = 0; i < 64; i++) step(~(64'd1 << i), 1'b0, "R5 walking-zero");

        // R7 / R1: exhaustive low eleven bits
        for (int n = 0; n < 2048; n++) begin
            logic [63:0] v;
            v       = {$urandom(), $urandom()};
            v[10:0] = n[10:0];
            step(v, 1'b0, "R7 sweep");
        end

        // R2 / R3: random vectors; R1: dense ones
        repeat (1500) step({$urandom(), $urandom()}, 1'b0, "R3 random");
        repeat (1500) step(~({$urandom(), $urandom()} & {$urandom(), $urandom()} &
                             {$urandom(), $urandom()} & {$urandom(), $urandom()} &
                             {$urandom(), $urandom()}), 1'b0, "R1 dense");

        // R8: held input keeps the result steady
        repeat (3) begin
            logic [63:0] v;
            v = {$urandom(), $urandom()};
            for (int k = 0; k < 12; k++) begin
                step(v, 1'b0, "R8 hold");
                for (int d = 0; d < NDUT; d++) begin
                    if (k >= lat[d] + 2) check(samp_s[d], prev_s[d], "R8", "hold steady", d);
                end
            end
        end

        // R6: reset in the middle of traffic, then R4 resume
        repeat (6) step({$urandom(), $urandom()}, 1'b0, "R4 pre-reset");
        step(64'd0, 1'b1, "R6 mid reset");
        repeat (3) step(64'd0, 1'b1, "R6 mid reset");
        step(64'd0, 1'b0, "R6 mid release");
        repeat (20) step({$urandom(), $urandom()}, 1'b0, "R4 resume");
        repeat (5) step(64'd0, 1'b0, "R4 drain");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule